// File: doc/BRIEF.md
# Prioritized Status LED Blink Sequencer

This block drives a single status LED from four active-low board status inputs. Time is divided into a repeating frame of eight equal slots, and each status condition is shown as its own fixed count of lit slots at the start of the frame. Only one condition is shown at a time, the one with the highest priority. When none of the status conditions is active, two software control bits decide whether the LED is steadily lit.

The status inputs cross into the clock domain through a two-stage synchroniser before priority resolution. The resolved condition is held in a register. Whenever the resolved condition changes, the slot timer and the slot index restart from slot 0, so a new pattern always begins with a full frame. Slot length is a parameter counted in clock cycles. The default gives about 125 ms per slot at 200 MHz, which makes one frame about one second long.

Top module: `led_blink_seq`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `led` is 0.
- R2: With `ext_rst_n` low, `led` is lit in all eight slots of the frame.
- R3: With `pwr_good` low as the highest active condition, `led` is lit in slots 0 to 4 and dark in slots 5 to 7.
- R4: With `board_en_n` low as the highest active condition, `led` is lit in slots 0 to 3 and dark in slots 4 to 7.
- R5: With `cfg_done` low as the only active condition, `led` is lit in slot 0 and dark in slots 1 to 7.
- R6: Priority from highest to lowest is `ext_rst_n`, `pwr_good`, `board_en_n`, `cfg_done`. A lower condition has no effect on `led` while a higher one is active.
- R7: With all four status inputs high, `led` is steadily 1 only when `sw_led` is 2'b11, and steadily 0 for 2'b00, 2'b01 and 2'b10. `sw_led` has no effect while any status condition is active. A change of `sw_led` reaches `led` on the next clock edge.
- R8: Each slot lasts exactly `SLOT_CYCLES` clock cycles, and the slots run 0 to 7 and then wrap back to 0.
- R9: When the resolved condition changes, the frame restarts at slot 0 with a full-length slot.
- R10: A status input change reaches `led` on the fourth rising clock edge after it is applied: two synchroniser stages, the condition register, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_rst_n | input | 1 | External reset request, active low (highest priority) |
| pwr_good | input | 1 | Power-good flag; 0 means a rail is down |
| board_en_n | input | 1 | Board enable, active low |
| cfg_done | input | 1 | Configuration done; 0 means the device is not configured |
| sw_led | input | 2 | Software control bits; the LED is lit when both are 1 and no status is active |
| led | output | 1 | LED drive, 1 = lit |

## Verification
The bench builds the block with `SLOT_CYCLES` = 3, with the synchroniser enabled at its default two stages. This gives a 24-cycle frame, so many whole frames fit into a short run for every priority level and for several conditions at once. It also lets the bench change the condition in the middle of a slot and check the restart at slot 0, and check the exact four-edge latency from a status input to the LED.

// File: rtl/led_seq_pkg.sv
// Package: shared types and constants for the status LED sequencer.
// Assumes an eight-slot frame; on-counts per condition are fixed here.
package led_seq_pkg;

    localparam int FRAME_SLOTS = 8;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);
    localparam int STS_W       = 4;

    // Raw status vector bit positions (all active low).
    localparam int STS_EXT  = 0;
    localparam int STS_PG   = 1;
    localparam int STS_EN   = 2;
    localparam int STS_DONE = 3;

    // Resolved condition; higher encoding = higher priority.
    typedef enum logic [2:0] {
        COND_SW   = 3'd0,
        COND_DONE = 3'd1,
        COND_EN   = 3'd2,
        COND_PG   = 3'd3,
        COND_EXT  = 3'd4
    } cond_e;

    // Number of lit slots at the head of the frame for each condition.
    function automatic logic [SLOT_W:0] lit_slots(input cond_e c);
        case (c)
            COND_EXT:  lit_slots = (SLOT_W+1)'(8);
            COND_PG:   lit_slots = (SLOT_W+1)'(5);
            COND_EN:   lit_slots = (SLOT_W+1)'(4);
            COND_DONE: lit_slots = (SLOT_W+1)'(1);
            default:   lit_slots = '0;
        endcase
    endfunction

endpackage

// File: rtl/led_seq_sync.sv
// Module: multi-stage synchroniser for the active-low status inputs.
// Assumes inputs are quasi-static levels; resets to all-ones (inactive).
// USE_SYNC = 0 selects a pass-through for inputs already in the clock domain.
module led_seq_sync #(
    parameter int W        = 4,
    parameter int STAGES   = 2,
    parameter bit USE_SYNC = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (USE_SYNC) begin : g_sync
            logic [W-1:0] stg [STAGES];
            logic         armed_q;

            // Shift the raw levels through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stg[i] <= '1;
                end else begin
                    stg[0] <= din;
                    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
                end
            end

            // Mark that at least one non-reset edge has loaded stage 0.
            always_ff @(posedge clk) begin
                if (!rst_n) armed_q <= 1'b0;
                else        armed_q <= 1'b1;
            end

            assign dout = stg[STAGES-1];

            AST_FIRST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
                armed_q |-> (stg[0] == $past(din)));  // R10
        end else begin : g_bypass
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/led_seq_prio.sv
// Module: fixed-priority resolver from synchronised status to one condition.
// Assumes active-low status bits in the package's bit positions.
module led_seq_prio
    import led_seq_pkg::*;
(
    input  logic [STS_W-1:0] sts_n,
    output cond_e            cond
);

    // Pick the highest-priority active condition, else software control.
    always_comb begin
        if (!sts_n[STS_EXT])       cond = COND_EXT;
        else if (!sts_n[STS_PG])   cond = COND_PG;
        else if (!sts_n[STS_EN])   cond = COND_EN;
        else if (!sts_n[STS_DONE]) cond = COND_DONE;
        else                       cond = COND_SW;
    end

endmodule

// File: rtl/led_seq_timer.sv
// Module: condition register plus slot timer.
// Holds the displayed condition; restarts the frame on any condition change.
// Assumes SLOT_CYCLES >= 1.
module led_seq_timer
    import led_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 25_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cond_e             cond_in,
    output cond_e             cond_q,
    output logic [SLOT_W-1:0] slot_q
);

    localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Latch the condition, count cycles in the slot, step the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= COND_SW;
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (cond_in != cond_q) begin
            cond_q <= cond_in;
            cnt_q  <= '0;
            slot_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            slot_q <= slot_q + 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_in != cond_q) |=> (slot_q == '0 && cnt_q == '0));  // R9
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_in == cond_q && cnt_q == CNT_LAST) |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1)));  // R8
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_in == cond_q && cnt_q != CNT_LAST) |=> $stable(slot_q));  // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);  // R8

endmodule

// File: rtl/led_seq_pattern.sv
// Module: registered LED drive from the condition, slot index and software bits.
// A status condition lights the head of the frame; otherwise software decides.
module led_seq_pattern
    import led_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cond_e             cond,
    input  logic [SLOT_W-1:0] slot,
    input  logic [1:0]        sw_led,
    output logic              led
);

    // Register the lit/dark decision for the current slot.
    always_ff @(posedge clk) begin
        if (!rst_n)              led <= 1'b0;
        else if (cond == COND_SW) led <= &sw_led;
        else                     led <= ({1'b0, slot} < lit_slots(cond));
    end

    AST_EXT_ALWAYS_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_EXT) |=> led);  // R2
    AST_PG_TAIL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_PG && slot >= SLOT_W'(5)) |=> !led);  // R3
    AST_EN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_EN) |=> (led == !$past(slot[SLOT_W-1])));  // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_DONE && slot != '0) |=> !led);  // R5
    AST_SW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == COND_SW && sw_led != 2'b11) |=> !led);  // R7

endmodule

// File: rtl/led_blink_seq.sv
// Module: top of the prioritized status LED blink sequencer.
// Chain: synchroniser -> priority resolver -> condition/slot timer -> LED register.
// Assumes a synchronous active-low reset and level status inputs.
module led_blink_seq
    import led_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 25_000_000,
    parameter int SYNC_STAGES = 2,
    parameter bit USE_SYNC    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst_n,
    input  logic       pwr_good,
    input  logic       board_en_n,
    input  logic       cfg_done,
    input  logic [1:0] sw_led,
    output logic       led
);

    logic [STS_W-1:0]  sts_raw;
    logic [STS_W-1:0]  sts_sync;
    cond_e             cond_now;
    cond_e             cond_q;
    logic [SLOT_W-1:0] slot_q;

    // Pack the raw status levels into their fixed bit positions.
    always_comb begin
        sts_raw           = '1;
        sts_raw[STS_EXT]  = ext_rst_n;
        sts_raw[STS_PG]   = pwr_good;
        sts_raw[STS_EN]   = board_en_n;
        sts_raw[STS_DONE] = cfg_done;
    end

    led_seq_sync #(
        .W        (STS_W),
        .STAGES   (SYNC_STAGES),
        .USE_SYNC (USE_SYNC)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sts_raw),
        .dout  (sts_sync)
    );

    led_seq_prio u_prio (
        .sts_n (sts_sync),
        .cond  (cond_now)
    );

    led_seq_timer #(
        .SLOT_CYCLES (SLOT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cond_in (cond_now),
        .cond_q  (cond_q),
        .slot_q  (slot_q)
    );

    led_seq_pattern u_pattern (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (cond_q),
        .slot   (slot_q),
        .sw_led (sw_led),
        .led    (led)
    );

    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_sync[STS_EXT] |=> (cond_q == COND_EXT));  // R6
    AST_PG_OVER_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_sync[STS_EXT] && !sts_sync[STS_PG]) |=> (cond_q == COND_PG));  // R6

endmodule

// File: tb/led_blink_seq_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the LED on every clock.
module led_blink_seq_bench;

    localparam int SLOT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       pwr_good = 1'b1;
    logic       board_en_n = 1'b1;
    logic       cfg_done = 1'b1;
    logic [1:0] sw_led = 2'b00;
    logic       led;

    int    vectors = 0;
    int    errors = 0;
    int    cycle = 0;
    bit    finished = 1'b0;
    bit    checking = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    logic [3:0] dly[$];
    int         m_cond = 0;
    int         m_cnt = 0;
    int         m_slot = 0;
    logic       m_led = 1'b0;

    always #2.5 clk = ~clk;

    led_blink_seq #(.SLOT_CYCLES(SLOT)) u_led_blink_seq (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .pwr_good(pwr_good),
        .board_en_n(board_en_n), .cfg_done(cfg_done), .sw_led(sw_led), .led(led)
    );

    // Priority order from the requirements: external reset, power good, enable, done.
    function automatic int resolve(logic [3:0] s);
        if (!s[0])      return 4;
        else if (!s[1]) return 3;
        else if (!s[2]) return 2;
        else if (!s[3]) return 1;
        return 0;
    endfunction

    function automatic int lit_count(int c);
        case (c)
            4: return 8;
            3: return 5;
            2: return 4;
            1: return 1;
            default: return 0;
        endcase
    endfunction

    initial begin
        dly.push_back(4'hF);
        dly.push_back(4'hF);
    end

    // Model update at each rising edge.
    always @(posedge clk) begin
        logic nl;
        int   nc;
        cycle++;
        if (!rst_n) begin
            dly.delete();
            dly.push_back(4'hF);
            dly.push_back(4'hF);
            m_cond = 0; m_cnt = 0; m_slot = 0; m_led = 1'b0;
        end else begin
            if (m_cond == 0) nl = (sw_led == 2'b11);
            else             nl = (m_slot < lit_count(m_cond));
            nc = resolve(dly[0]);
            if (nc != m_cond) begin
                m_cond = nc; m_cnt = 0; m_slot = 0;
            end else if (m_cnt == SLOT - 1) begin
                m_cnt = 0; m_slot = (m_slot + 1) % 8;
            end else begin
                m_cnt++;
            end
            void'(dly.pop_front());
            dly.push_back({cfg_done, board_en_n, pwr_good, ext_rst_n});
            m_led = nl;
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (checking && !finished) begin
            vectors++;
            if (led !== m_led) begin
                errors++;
                $display("FAIL %s: led=%0b expected %0b at cycle %0d", cur_req, led, m_led, cycle);
            end
        end
    end

    task automatic run(string tag, int n);
        cur_req = tag;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sts(logic e, logic p, logic b, logic d);
        ext_rst_n = e; pwr_good = p; board_en_n = b; cfg_done = d;
    endtask

    task automatic expect_led(string tag, logic exp);
        vectors++;
        if (led !== exp) begin
            errors++;
            $display("FAIL %s: led=%0b expected %0b at cycle %0d", tag, led, exp, cycle);
        end
    endtask

    initial begin
        @(negedge clk);
        checking = 1'b1;
        run("R1", 4);
        rst_n = 1'b1;
        run("R1", 1);
        expect_led("R1", 1'b0);

        // R7: software fallback, every bit combination.
        sw_led = 2'b00; run("R7", 8);
        sw_led = 2'b01; run("R7", 8);
        sw_led = 2'b10; run("R7", 8);
        sw_led = 2'b11; run("R7", 1);
        expect_led("R7", 1'b1);
        run("R7", 8);
        sw_led = 2'b00; run("R7", 6);

        // R10: exact latency; LED lit on the fourth edge after the change.
        set_sts(1'b0, 1'b1, 1'b1, 1'b1);
        run("R10", 3);
        expect_led("R10", 1'b0);
        run("R10", 1);
        expect_led("R10", 1'b1);

        // Each single condition over several frames.
        run("R2", 60);
        set_sts(1'b1, 1'b0, 1'b1, 1'b1); run("R3", 60);
        set_sts(1'b1, 1'b1, 1'b0, 1'b1); run("R4", 60);
        set_sts(1'b1, 1'b1, 1'b1, 1'b0); run("R5", 60);
        set_sts(1'b1, 1'b1, 1'b1, 1'b1); sw_led = 2'b11; run("R8", 30);

        // R6: several conditions together; software bits must not matter.
        set_sts(1'b0, 1'b0, 1'b0, 1'b0); sw_led = 2'b11; run("R6", 60);
        set_sts(1'b1, 1'b0, 1'b1, 1'b0); sw_led = 2'b00; run("R6", 60);
        set_sts(1'b1, 1'b1, 1'b0, 1'b0); sw_led = 2'b11; run("R6", 60);
        sw_led = 2'b01; run("R6", 30);

        // R9: change condition mid-slot; the new frame restarts at slot 0.
        set_sts(1'b1, 1'b1, 1'b0, 1'b1); run("R9", 13);
        set_sts(1'b1, 1'b0, 1'b1, 1'b1); run("R9", 40);
        set_sts(1'b1, 1'b1, 1'b1, 1'b0); run("R9", 17);
        set_sts(1'b1, 1'b1, 1'b0, 1'b1); run("R9", 50);

        // R1: reset in the middle of a pattern.
        set_sts(1'b0, 1'b1, 1'b1, 1'b1); run("R2", 10);
        rst_n = 1'b0; run("R1", 1);
        expect_led("R1", 1'b0);
        run("R1", 3);
        rst_n = 1'b1; run("R1", 1);
        expect_led("R1", 1'b0);
        run("R2", 40);
        set_sts(1'b1, 1'b1, 1'b1, 1'b1); sw_led = 2'b10; run("R7", 20);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(5 * 20000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: led=%0b expected run end at cycle %0d", led, cycle);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule